// File: doc/BRIEF.md
# USB Subsystem Boot Reset Sequencer

This block runs exactly once after the chip-level reset is released. It brings the USB subsystem out of reset in a safe order. It acts as a small master on a register bus that reaches two address spaces: the peripheral-reset space and the global-control space. First it reads a module-disable strap word. From that word it works out which USB device controllers take part in the bring-up. It then does the following, in order:

- puts the selected device controllers, the host controller(s) and the PHYs into reset;
- stops every PHY through the run bit in its control register;
- releases the PHYs alone;
- waits for a settle time;
- restarts the PHYs;
- finally releases every device and host reset that it asserted.

Every register update is a read followed by a write of the modified value. Bits outside the masks the sequencer owns therefore keep their value.

The parameter `WIDE` selects one of two variants:

- **Wide:** four reset registers and three PHYs.
- **Narrow:** three reset registers and two PHYs.

The settle wait is a cycle counter of `CLK_MHZ * SETTLE_US` cycles. When the last write has been issued, a sticky done flag rises. It stays high until the next global reset.

Top module: `usb_boot_rst_seq`

## Requirements
- R1: While `rst_n` is low, `bus_rd`, `bus_wr` and `seq_done` are all 0.
- R2: The first bus access after reset is a read of the strap word at global-space (`bus_glb`=1) offset 0x07C, and that address is never written.
- R3: Read data is taken from `bus_rdata` in the cycle after `bus_rd`. Every write goes to the space and address read in the previous cycle. Its data is (read value AND keep-mask) OR set-mask, and `bus_rd` and `bus_wr` are never high together.
- R4: The assert phase writes the reset-space registers in this order: 0x020, 0x024, 0x034, then 0x074 (wide only). It always sets bit 26 of 0x024 (host) and bits 24 and 25 of 0x034 (PHY1, PHY2). In the wide variant it also always sets bit 31 (second host) and bit 25 (third PHY) of 0x074.
- R5: Wide variant, where a strap bit of 0 selects its group:
  - strap bit 9 selects 0x034 bit 4 and 0x020 bits 5, 8 and 25;
  - strap bit 22 selects 0x020 bits 22, 23 and 24, and 0x034 bit 5;
  - strap bit 24 selects 0x034 bit 6;
  - strap bit 21 selects 0x034 bit 7.
- R6: Narrow variant, where a strap bit of 0 selects its group:
  - strap bit 9 selects 0x034 bit 4;
  - strap bit 8 selects 0x020 bit 5;
  - strap bit 21 selects 0x020 bits 8, 22 and 25;
  - strap bit 22 selects 0x020 bits 23 and 24, and 0x034 bits 5, 6 and 7.
- R7: After the assert phase, bit 28 (run) is cleared in the global-space PHY control registers 0x140 and 0x144, and in 0x148 (wide only), in that order.
- R8: The PHY release phase then clears only bits 24 and 25 of 0x034 and, in the wide variant, bit 25 of 0x074. Device and host resets stay set.
- R9: The first PHY-restart write comes exactly `CLK_MHZ*SETTLE_US + 2` cycles after the last PHY-release write.
- R10: The restart phase sets bit 28 in each PHY control register, in the same order as R7. The release phase then clears every bit set in the assert phase except the PHY1/PHY2 bits, in the order 0x020, 0x024, 0x034, then 0x074 (wide only).
- R11: `seq_done` rises in the cycle after the final write and stays high. No further bus access happens until the next reset. In the end every bit outside the owned masks holds its original value.
- R12: The wide variant makes exactly 16 writes. The narrow variant makes exactly 11 and never addresses 0x074 or 0x148. No access goes outside the eight listed addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| bus_rd | output | 1 | Read strobe; data expected one cycle later |
| bus_wr | output | 1 | Write strobe |
| bus_glb | output | 1 | Space select: 1 = global-control, 0 = peripheral-reset |
| bus_addr | output | 12 | Byte offset inside the selected space |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_rd` |
| seq_done | output | 1 | Sticky sequence-complete flag |

## Verification
A wrong step index or a skipped variant step shows up at once as a write to the wrong address, or a write out of order. A wrong captured strap word, or a wrong mask decode, corrupts the data of the very first assert-phase write and of the matching release-phase write. A miscounted settle counter moves the first PHY-restart write away from its exact cycle. A broken done flag shows up in the cycle after the last write, or as bus traffic after completion. Straps are swept over every combination of the four selecting bits in both variants, and the bus model starts from a different pattern on each pass, so mask leakage into unrelated bits is caught in the final register contents.

// File: rtl/usbrst_pkg.sv
package usbrst_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 12;
    localparam int STEP_W = 5;

    // register offsets (peripheral-reset space)
    localparam logic [ADDR_W-1:0] OFS_RST_A = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_RST_B = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_RST_C = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_RST_D = 12'h074;
    // global-control space
    localparam logic [ADDR_W-1:0] OFS_STRAP = 12'h07C;
    localparam logic [ADDR_W-1:0] OFS_PHY0  = 12'h140;
    localparam logic [ADDR_W-1:0] OFS_PHY1  = 12'h144;
    localparam logic [ADDR_W-1:0] OFS_PHY2  = 12'h148;

    localparam int BIT_RUN   = 28;
    localparam int BIT_HOST  = 26;
    localparam int BIT_HOST2 = 31;
    localparam int BIT_PHYC  = 25;

    localparam logic [REG_W-1:0] RUN_MASK  = REG_W'(1) << BIT_RUN;
    localparam logic [REG_W-1:0] PHYAB_MSK = (REG_W'(1) << 24) | (REG_W'(1) << 25);
    localparam logic [REG_W-1:0] PHYC_MSK  = REG_W'(1) << BIT_PHYC;

    // step numbering; the order is the bring-up order
    localparam logic [STEP_W-1:0] STP_STRAP = 5'd0;
    localparam logic [STEP_W-1:0] STP_SETA  = 5'd1;
    localparam logic [STEP_W-1:0] STP_SETB  = 5'd2;
    localparam logic [STEP_W-1:0] STP_SETC  = 5'd3;
    localparam logic [STEP_W-1:0] STP_SETD  = 5'd4;
    localparam logic [STEP_W-1:0] STP_STOP0 = 5'd5;
    localparam logic [STEP_W-1:0] STP_STOP1 = 5'd6;
    localparam logic [STEP_W-1:0] STP_STOP2 = 5'd7;
    localparam logic [STEP_W-1:0] STP_PHYC  = 5'd8;
    localparam logic [STEP_W-1:0] STP_PHYD  = 5'd9;
    localparam logic [STEP_W-1:0] STP_WAIT  = 5'd10;
    localparam logic [STEP_W-1:0] STP_RUN0  = 5'd11;
    localparam logic [STEP_W-1:0] STP_RUN1  = 5'd12;
    localparam logic [STEP_W-1:0] STP_RUN2  = 5'd13;
    localparam logic [STEP_W-1:0] STP_CLRA  = 5'd14;
    localparam logic [STEP_W-1:0] STP_CLRB  = 5'd15;
    localparam logic [STEP_W-1:0] STP_CLRC  = 5'd16;
    localparam logic [STEP_W-1:0] STP_CLRD  = 5'd17;
    localparam logic [STEP_W-1:0] STP_END   = 5'd18;

    typedef enum logic [1:0] {
        SQ_RD   = 2'd0,
        SQ_WR   = 2'd1,
        SQ_WAIT = 2'd2,
        SQ_DONE = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [REG_W-1:0] rc;
        logic [REG_W-1:0] rd;
    } rst_masks_t;

    typedef struct packed {
        logic              glb;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  keep;
        logic [REG_W-1:0]  set;
        logic              rd_only;
    } bus_op_t;

    typedef struct packed {
        seq_state_t        st;
        logic [STEP_W-1:0] step;
        logic [REG_W-1:0]  strap;
    } seq_regs_t;

    // steps that exist only in the wide variant
    function automatic logic wide_only(input logic [STEP_W-1:0] s);
        return (s == STP_SETD) || (s == STP_STOP2) || (s == STP_PHYD) ||
               (s == STP_RUN2) || (s == STP_CLRD);
    endfunction

endpackage

// File: rtl/usbrst_strap_decode.sv
module usbrst_strap_decode
    import usbrst_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic [REG_W-1:0] strap,
    output rst_masks_t       masks
);

    function automatic logic [REG_W-1:0] bm(input int b);
        return REG_W'(1) << b;
    endfunction

    logic unused_strap;
    assign unused_strap = ^strap;

    generate
        if (WIDE) begin : g_wide
            always_comb begin
                masks    = '0;
                masks.rb = bm(BIT_HOST);
                masks.rd = bm(BIT_HOST2) | PHYC_MSK;
                if (!strap[9]) begin
                    masks.rc = masks.rc | bm(4);
                    masks.ra = masks.ra | bm(5) | bm(8) | bm(25);
                end
                if (!strap[22]) begin
                    masks.ra = masks.ra | bm(22) | bm(23) | bm(24);
                    masks.rc = masks.rc | bm(5);
                end
                if (!strap[24]) masks.rc = masks.rc | bm(6);
                if (!strap[21]) masks.rc = masks.rc | bm(7);
            end
        end else begin : g_narrow
            always_comb begin
                masks    = '0;
                masks.rb = bm(BIT_HOST);
                if (!strap[9])  masks.rc = masks.rc | bm(4);
                if (!strap[8])  masks.ra = masks.ra | bm(5);
                if (!strap[21]) masks.ra = masks.ra | bm(8) | bm(22) | bm(25);
                if (!strap[22]) begin
                    masks.ra = masks.ra | bm(23) | bm(24);
                    masks.rc = masks.rc | bm(5) | bm(6) | bm(7);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/usbrst_step_rom.sv
module usbrst_step_rom
    import usbrst_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  rst_masks_t        masks,
    output bus_op_t           op
);

    always_comb begin
        op.glb     = 1'b0;
        op.addr    = '0;
        op.keep    = '1;
        op.set     = '0;
        op.rd_only = 1'b0;
        case (step)
            STP_STRAP: begin op.glb = 1'b1; op.addr = OFS_STRAP; op.rd_only = 1'b1; end
            STP_SETA:  begin op.addr = OFS_RST_A; op.set = masks.ra; end
            STP_SETB:  begin op.addr = OFS_RST_B; op.set = masks.rb; end
            STP_SETC:  begin op.addr = OFS_RST_C; op.set = masks.rc | PHYAB_MSK; end
            STP_SETD:  begin op.addr = OFS_RST_D; op.set = masks.rd; end
            STP_STOP0: begin op.glb = 1'b1; op.addr = OFS_PHY0; op.keep = ~RUN_MASK; end
            STP_STOP1: begin op.glb = 1'b1; op.addr = OFS_PHY1; op.keep = ~RUN_MASK; end
            STP_STOP2: begin op.glb = 1'b1; op.addr = OFS_PHY2; op.keep = ~RUN_MASK; end
            STP_PHYC:  begin op.addr = OFS_RST_C; op.keep = ~PHYAB_MSK; end
            STP_PHYD:  begin op.addr = OFS_RST_D; op.keep = ~PHYC_MSK; end
            STP_RUN0:  begin op.glb = 1'b1; op.addr = OFS_PHY0; op.set = RUN_MASK; end
            STP_RUN1:  begin op.glb = 1'b1; op.addr = OFS_PHY1; op.set = RUN_MASK; end
            STP_RUN2:  begin op.glb = 1'b1; op.addr = OFS_PHY2; op.set = RUN_MASK; end
            STP_CLRA:  begin op.addr = OFS_RST_A; op.keep = ~masks.ra; end
            STP_CLRB:  begin op.addr = OFS_RST_B; op.keep = ~masks.rb; end
            STP_CLRC:  begin op.addr = OFS_RST_C; op.keep = ~masks.rc; end
            STP_CLRD:  begin op.addr = OFS_RST_D; op.keep = ~masks.rd; end
            default:   begin op.rd_only = 1'b1; end
        endcase
    end

endmodule

// File: rtl/usbrst_settle_timer.sv
module usbrst_settle_timer #(
    parameter int unsigned TERM = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = (TERM > 1) ? $clog2(TERM) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)        cnt_d = '0;
        else if (!expired) cnt_d = cnt_q + CW'(1);
    end

    assign expired = run && (cnt_q == CW'(TERM - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/usb_boot_rst_seq.sv
module usb_boot_rst_seq
    import usbrst_pkg::*;
#(
    parameter bit          WIDE      = 1'b1,
    parameter int unsigned CLK_MHZ   = 200,
    parameter int unsigned SETTLE_US = 50
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic                     bus_rd,
    output logic                     bus_wr,
    output logic                     bus_glb,
    output logic [usbrst_pkg::ADDR_W-1:0] bus_addr,
    output logic [usbrst_pkg::REG_W-1:0]  bus_wdata,
    input  logic [usbrst_pkg::REG_W-1:0]  bus_rdata,
    output logic                     seq_done
);

    localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;

    seq_regs_t         r_d, r_q;
    rst_masks_t        masks;
    bus_op_t           op;
    logic              settle_ok;
    logic [STEP_W-1:0] step_inc, step_nxt;

    usbrst_strap_decode #(.WIDE(WIDE)) u_dec (
        .strap (r_q.strap),
        .masks (masks)
    );

    usbrst_step_rom u_rom (
        .step  (r_q.step),
        .masks (masks),
        .op    (op)
    );

    usbrst_settle_timer #(.TERM(SETTLE_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == SQ_WAIT),
        .expired (settle_ok)
    );

    // next step, skipping wide-only steps in the narrow variant
    always_comb begin
        step_inc = r_q.step + STEP_W'(1);
        if (!WIDE && wide_only(step_inc)) step_nxt = step_inc + STEP_W'(1);
        else                              step_nxt = step_inc;
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            SQ_RD: r_d.st = SQ_WR;
            SQ_WR: begin
                if (op.rd_only) r_d.strap = bus_rdata;
                r_d.step = step_nxt;
                if (step_nxt == STP_WAIT)     r_d.st = SQ_WAIT;
                else if (step_nxt == STP_END) r_d.st = SQ_DONE;
                else                          r_d.st = SQ_RD;
            end
            SQ_WAIT: begin
                if (settle_ok) begin
                    r_d.step = STP_RUN0;
                    r_d.st   = SQ_RD;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= SQ_RD;
            r_q.step  <= STP_STRAP;
            r_q.strap <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // bus outputs held idle while reset is active
    assign bus_rd    = rst_n && (r_q.st == SQ_RD);
    assign bus_wr    = rst_n && (r_q.st == SQ_WR) && !op.rd_only;
    assign bus_glb   = op.glb;
    assign bus_addr  = op.addr;
    assign bus_wdata = (bus_rdata & op.keep) | op.set;
    assign seq_done  = (r_q.st == SQ_DONE);

endmodule

// File: rtl/usb_boot_rst_seq_chk.sv
module usb_boot_rst_seq_chk
    import usbrst_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_glb,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              seq_done
);

    assert_idle_in_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (!bus_rd && !bus_wr && !seq_done));

    assert_strap_not_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> !(bus_glb && bus_addr == OFS_STRAP));

    assert_no_rd_wr_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ($past(bus_rd) && $past(bus_addr) == bus_addr && $past(bus_glb) == bus_glb));

    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> seq_done);

    assert_quiet_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!bus_rd && !bus_wr));

    assert_done_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> $past(bus_wr));

    assert_narrow_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_addr == OFS_RST_A || bus_addr == OFS_RST_B ||
                                bus_addr == OFS_RST_C || bus_addr == OFS_RST_D ||
                                bus_addr == OFS_STRAP || bus_addr == OFS_PHY0  ||
                                bus_addr == OFS_PHY1  || bus_addr == OFS_PHY2));

endmodule

bind usb_boot_rst_seq usb_boot_rst_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_glb  (bus_glb),
    .bus_addr (bus_addr),
    .seq_done (seq_done)
);

// File: tb/usb_boot_rst_seq_test.sv
`timescale 1ns/1ps
module usb_boot_rst_seq_test;

    localparam int TERM = 200;   // 200 MHz * 1 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        rd_v [2];
    logic        wr_v [2];
    logic        glb_v [2];
    logic [11:0] addr_v [2];
    logic [31:0] wdata_v [2];
    logic [31:0] rdata_v [2];
    logic        done_v [2];

    // index 0: wide variant, index 1: narrow variant
    usb_boot_rst_seq #(.WIDE(1'b1), .CLK_MHZ(200), .SETTLE_US(1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(rd_v[0]), .bus_wr(wr_v[0]), .bus_glb(glb_v[0]),
        .bus_addr(addr_v[0]), .bus_wdata(wdata_v[0]), .bus_rdata(rdata_v[0]), .seq_done(done_v[0]));

    usb_boot_rst_seq #(.WIDE(1'b0), .CLK_MHZ(200), .SETTLE_US(1)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .bus_rd(rd_v[1]), .bus_wr(wr_v[1]), .bus_glb(glb_v[1]),
        .bus_addr(addr_v[1]), .bus_wdata(wdata_v[1]), .bus_rdata(rdata_v[1]), .seq_done(done_v[1]));

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] mem   [2][8];
    logic [31:0] init_m[2][8];
    logic        pg    [2][16];
    logic [11:0] pa    [2][16];
    logic [31:0] pkeep [2][16];
    logic [31:0] pset  [2][16];
    string       ptag  [2][16];
    int          plen  [2];
    logic [31:0] mk    [2][4];
    int          wcnt  [2];
    int          rcnt  [2];
    int          cyc   [2];
    int          wcyc  [2][16];
    bit          done_seen [2];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int midx(input logic g, input logic [11:0] a);
        if (!g) begin
            case (a)
                12'h020: return 0;
                12'h024: return 1;
                12'h034: return 2;
                12'h074: return 3;
                default: return -1;
            endcase
        end
        case (a)
            12'h07C: return 4;
            12'h140: return 5;
            12'h144: return 6;
            12'h148: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] b(input int n);
        return 32'd1 << n;
    endfunction

    task automatic add_op(input int v, input logic g, input logic [11:0] a,
                          input logic [31:0] kp, input logic [31:0] st, input string tg);
        pg[v][plen[v]] = g; pa[v][plen[v]] = a;
        pkeep[v][plen[v]] = kp; pset[v][plen[v]] = st; ptag[v][plen[v]] = tg;
        plen[v]++;
    endtask

    // expected write list from the requirements
    task automatic build_plan(input int v, input logic [31:0] s);
        logic w;
        logic [31:0] m1, m2, m3, m4, phy, run;
        w = (v == 0);
        phy = b(24) | b(25);
        run = b(28);
        m2 = b(26);
        if (w) begin
            m1 = (!s[9] ? (b(5) | b(8) | b(25)) : 32'd0) | (!s[22] ? (b(22) | b(23) | b(24)) : 32'd0);
            m3 = (!s[9] ? b(4) : 32'd0) | (!s[22] ? b(5) : 32'd0) |
                 (!s[24] ? b(6) : 32'd0) | (!s[21] ? b(7) : 32'd0);
            m4 = b(31) | b(25);
        end else begin
            m1 = (!s[8] ? b(5) : 32'd0) | (!s[21] ? (b(8) | b(22) | b(25)) : 32'd0) |
                 (!s[22] ? (b(23) | b(24)) : 32'd0);
            m3 = (!s[9] ? b(4) : 32'd0) | (!s[22] ? (b(5) | b(6) | b(7)) : 32'd0);
            m4 = 32'd0;
        end
        mk[v][0] = m1; mk[v][1] = m2; mk[v][2] = m3; mk[v][3] = m4;
        plen[v] = 0;
        add_op(v, 1'b0, 12'h020, '1, m1, w ? "R4/R5" : "R4/R6");
        add_op(v, 1'b0, 12'h024, '1, m2, "R4");
        add_op(v, 1'b0, 12'h034, '1, m3 | phy, w ? "R4/R5" : "R4/R6");
        if (w) add_op(v, 1'b0, 12'h074, '1, m4, "R4");
        add_op(v, 1'b1, 12'h140, ~run, '0, "R7");
        add_op(v, 1'b1, 12'h144, ~run, '0, "R7");
        if (w) add_op(v, 1'b1, 12'h148, ~run, '0, "R7");
        add_op(v, 1'b0, 12'h034, ~phy, '0, "R8");
        if (w) add_op(v, 1'b0, 12'h074, ~b(25), '0, "R8");
        add_op(v, 1'b1, 12'h140, '1, run, "R10");
        add_op(v, 1'b1, 12'h144, '1, run, "R10");
        if (w) add_op(v, 1'b1, 12'h148, '1, run, "R10");
        add_op(v, 1'b0, 12'h020, ~m1, '0, "R10");
        add_op(v, 1'b0, 12'h024, ~m2, '0, "R10");
        add_op(v, 1'b0, 12'h034, ~m3, '0, "R10");
        if (w) add_op(v, 1'b0, 12'h074, ~m4, '0, "R10");
    endtask

    // bus model and monitor, all activity on the falling edge
    always @(negedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (!rst_n) begin
                chk(!rd_v[v] && !wr_v[v] && !done_v[v], "R1",
                    {29'd0, rd_v[v], wr_v[v], done_v[v]}, 32'd0);
                wcnt[v] = 0; rcnt[v] = 0; cyc[v] = 0; done_seen[v] = 1'b0;
            end else begin
                int ix;
                logic [31:0] expd;
                cyc[v]++;
                if (rd_v[v]) begin
                    ix = midx(glb_v[v], addr_v[v]);
                    if (rcnt[v] == 0)
                        chk(glb_v[v] && addr_v[v] == 12'h07C, "R2", {19'd0, glb_v[v], addr_v[v]}, 32'h107C);
                    chk(ix >= 0, "R12", {19'd0, glb_v[v], addr_v[v]}, 32'd0);
                    rdata_v[v] = (ix >= 0) ? mem[v][ix] : 32'hDEAD_BEEF;
                    rcnt[v]++;
                end
                if (wr_v[v]) begin
                    ix = midx(glb_v[v], addr_v[v]);
                    if (wcnt[v] < plen[v]) begin
                        chk(glb_v[v] == pg[v][wcnt[v]] && addr_v[v] == pa[v][wcnt[v]], ptag[v][wcnt[v]],
                            {19'd0, glb_v[v], addr_v[v]}, {19'd0, pg[v][wcnt[v]], pa[v][wcnt[v]]});
                        expd = (ix >= 0) ? ((mem[v][ix] & pkeep[v][wcnt[v]]) | pset[v][wcnt[v]]) : 32'hDEAD_BEEF;
                        chk(wdata_v[v] == expd, "R3", wdata_v[v], expd);
                        wcyc[v][wcnt[v]] = cyc[v];
                    end else begin
                        chk(1'b0, "R12", wcnt[v], plen[v]);
                    end
                    if (ix >= 0) mem[v][ix] = wdata_v[v];
                    wcnt[v]++;
                end
                if (done_v[v] && !done_seen[v]) begin
                    chk(wcnt[v] == plen[v] && cyc[v] == wcyc[v][plen[v]-1] + 1, "R11", cyc[v], wcyc[v][plen[v]-1] + 1);
                    done_seen[v] = 1'b1;
                end else if (done_seen[v]) begin
                    chk(done_v[v] && !rd_v[v] && !wr_v[v], "R11",
                        {29'd0, done_v[v], rd_v[v], wr_v[v]}, 32'd4);
                end
            end
        end
    end

    task automatic run_case(input int i);
        logic [31:0] noise, s0, s1;
        @(posedge clk); #1 rst_n = 1'b0;
        noise = 32'h9E37_79B9 * (i + 3);
        s0 = (noise & ~(b(9) | b(22) | b(24) | b(21))) |
             (i[0] ? b(9) : 0) | (i[1] ? b(22) : 0) | (i[2] ? b(24) : 0) | (i[3] ? b(21) : 0);
        s1 = (noise & ~(b(9) | b(8) | b(21) | b(22))) |
             (i[0] ? b(9) : 0) | (i[1] ? b(8) : 0) | (i[2] ? b(21) : 0) | (i[3] ? b(22) : 0);
        for (int v = 0; v < 2; v++) begin
            for (int j = 0; j < 8; j++) begin
                mem[v][j] = 32'h6A09_E667 ^ (32'h85EB_CA6B * (i * 8 + j + 1));
            end
            mem[v][4] = (v == 0) ? s0 : s1;
            for (int j = 0; j < 8; j++) init_m[v][j] = mem[v][j];
            build_plan(v, mem[v][4]);
            rdata_v[v] = 32'd0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int c = 0; c < 3000 && !(done_seen[0] && done_seen[1]); c++) @(posedge clk);
        repeat (8) @(posedge clk);
        #1;
        for (int v = 0; v < 2; v++) begin
            logic [31:0] e;
            chk(wcnt[v] == ((v == 0) ? 16 : 11), "R12", wcnt[v], (v == 0) ? 16 : 11);
            chk(done_seen[v], "R11", {31'd0, done_seen[v]}, 32'd1);
            if (wcnt[v] == plen[v]) begin
                if (v == 0) chk(wcyc[v][9] - wcyc[v][8] == TERM + 2, "R9", wcyc[v][9] - wcyc[v][8], TERM + 2);
                else        chk(wcyc[v][6] - wcyc[v][5] == TERM + 2, "R9", wcyc[v][6] - wcyc[v][5], TERM + 2);
            end
            e = init_m[v][0] & ~mk[v][0];
            chk(mem[v][0] == e, (v == 0) ? "R5/R11" : "R6/R11", mem[v][0], e);
            e = init_m[v][1] & ~mk[v][1];
            chk(mem[v][1] == e, "R11", mem[v][1], e);
            e = init_m[v][2] & ~(mk[v][2] | b(24) | b(25));
            chk(mem[v][2] == e, (v == 0) ? "R5/R11" : "R6/R11", mem[v][2], e);
            e = init_m[v][3] & ~mk[v][3];
            chk(mem[v][3] == e, (v == 0) ? "R11" : "R12", mem[v][3], e);
            chk(mem[v][4] == init_m[v][4], "R2", mem[v][4], init_m[v][4]);
            e = init_m[v][5] | b(28);
            chk(mem[v][5] == e, "R10", mem[v][5], e);
            e = init_m[v][6] | b(28);
            chk(mem[v][6] == e, "R10", mem[v][6], e);
            e = (v == 0) ? (init_m[v][7] | b(28)) : init_m[v][7];
            chk(mem[v][7] == e, (v == 0) ? "R10" : "R12", mem[v][7], e);
        end
    endtask

    initial begin
        for (int v = 0; v < 2; v++) begin
            rdata_v[v] = 32'd0;
            plen[v] = 0;
        end
        for (int i = 0; i < 16; i++) run_case(i);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule